// File: doc/BRIEF.md
# S/PDIF Subframe Transmitter

This block turns audio words from a transmit FIFO into a biphase-mark-coded S/PDIF line. Each word carries a 24-bit sample and the validity, user, channel-status and parity bits of one subframe. Two subframes (left, then right) form a frame, and 192 frames form a block. The block pulls words through a ready/valid handshake and emits one half-cell per pulse of a strobe that runs at twice the cell rate. Its control inputs select the transfer direction, the enable, stereo or single-channel operation, which channel a single-channel stream repeats, whether parity is computed or passed through, and an optional hold-off before the first block-start preamble.

A five-state machine drives the sequence. `ST_IDLE` is the rest state, entered from any state whenever the block is disabled or set to receive. From there it moves to `ST_HOLD` if the hold-off is selected, otherwise straight to `ST_FETCH_A`. `ST_HOLD` counts strobe pulses down from the programmed delay and moves to `ST_FETCH_A` when the count reaches zero. `ST_FETCH_A` takes one FIFO word. In stereo it then moves to `ST_SEND`. In single-channel mode it moves to `ST_FETCH_B`, which takes a second word and then moves to `ST_SEND`. `ST_SEND` emits 64 half-cells. At the end of a subframe it returns to `ST_FETCH_A`. The one exception is a single-channel left subframe: there it stays in `ST_SEND` and sends the right subframe from the words already held.

When a fetch finds the FIFO empty, the block sends an all-zero word and sets a sticky underrun flag. A one-cycle clear pulse resets the flag. Upper FIFO bits beyond bit 27 are not carried on the port.

Top module: `spdif_tx`

## Requirements
- R1: Subframes alternate left then right. The left subframe of frame 0 of each block starts with preamble B, other left subframes with M, and right subframes with W. The 8 half-cells, first to last, are B=11101000, M=11100010 and W=11100100 when the line was low before the preamble. The pattern is inverted when the line was high.
- R2: Word bits [23:0] are sent LSB first in slots 4 to 27. Bit 24 (V) is sent in slot 28, bit 25 (U) in slot 29, bit 26 (C) in slot 30 and the parity bit in slot 31. Slots 0 to 3 hold the preamble.
- R3: Every data slot (4 to 31) begins with a line transition. A slot carrying 1 has a second transition at mid-cell; a slot carrying 0 has none.
- R4: With parity generation on, slot 31 makes slots 4 to 31 even parity, whatever word bit 27 holds.
- R5: With parity generation off, word bit 27 is sent unchanged in slot 31.
- R6: In single-channel mode, two words are fetched per frame (first = primary/left, second = secondary/right). Duplicate = 1 sends the first word in both subframes; duplicate = 0 sends the second word in both.
- R7: With the hold-off selected and delay D, the first preamble B starts exactly D half-cell periods later than with the hold-off clear.
- R8: A block is 192 frames. Frame 191 left uses M and frame 192 left uses B again.
- R9: A fetch from an empty FIFO sets the sticky underrun flag and sends an all-zero word (parity computed). A clear pulse with no fetch pending resets the flag.
- R10: While receive is selected or enable is low, fifo_ready stays 0, no word is consumed and the line stays low.
- R11: Dropping enable brings the line low within two clocks and resets frame position. The next enable starts again from low with preamble B.
- R12: After reset, sdo, underrun and fifo_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_en | input | 1 | Half-cell strobe (twice the cell rate) |
| cfg_enable | input | 1 | Block enable; 0 resets transmit state |
| cfg_tx_mode | input | 1 | 1 = transmit direction, 0 = receive (block idle) |
| cfg_mono | input | 1 | 1 = single-channel, 0 = two-channel |
| cfg_dup_primary | input | 1 | Single-channel: 1 repeat primary word, 0 repeat secondary |
| cfg_gen_parity | input | 1 | 1 = compute parity, 0 = pass word bit 27 |
| cfg_hold_first_b | input | 1 | 1 = delay first preamble B |
| cfg_first_b_delay | input | DLY_W | Hold-off in half-cell periods |
| fifo_word | input | 28 | FIFO entry: sample [23:0], V, U, C, P |
| fifo_valid | input | 1 | FIFO has a word |
| fifo_ready | output | 1 | Word taken this cycle when valid |
| underrun_clr | input | 1 | Pulse clears the underrun flag |
| underrun | output | 1 | Sticky transmit underrun |
| sdo | output | 1 | Biphase-mark serial line |

## Verification
The hardest point to reach is the wrap of the 192-frame block. Seeing preamble B return needs more than 24,000 half-cells, far more than a word list can feed. The stimulus therefore leaves the FIFO empty, so every fetch underruns and sends zeros, and the run goes on past frame 192. The bench decodes the recorded line itself, using the transition rules and the level before each preamble.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

    localparam int SLOTS     = 32;
    localparam int PRE_SLOTS = 4;
    localparam int PAY_BITS  = 28;

    typedef enum logic [1:0] {
        PRE_B,
        PRE_M,
        PRE_W
    } pre_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_SEND
    } tx_state_e;

    // Half-cell pattern from a low line, MSB sent first.
    function automatic logic [7:0] pre_pattern(input pre_e kind);
        logic [7:0] p;
        unique case (kind)
            PRE_B:   p = 8'b1110_1000;
            PRE_M:   p = 8'b1110_0010;
            default: p = 8'b1110_0100;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/spdif_tx_ctrl.sv
module spdif_tx_ctrl
    import spdif_tx_pkg::*;
#(
    parameter int FRAMES = 192,
    parameter int DLY_W  = 8,
    localparam int FW    = $clog2(FRAMES),
    localparam int HW    = $clog2(2 * SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cell_en,
    input  logic                go,
    input  logic                mono,
    input  logic                dup_primary,
    input  logic                gen_parity,
    input  logic                hold_first_b,
    input  logic [DLY_W-1:0]    first_b_delay,
    input  logic [PAY_BITS-1:0] fifo_word,
    input  logic                fifo_valid,
    output logic                fifo_ready,
    input  logic                underrun_clr,
    output logic                underrun,
    output logic                fire,
    output logic                line_clear,
    output logic [HW-1:0]       half_idx,
    output pre_e                pre_kind,
    output logic [PAY_BITS-1:0] payload
);

    localparam logic [HW-1:0] LAST_HALF  = HW'(2 * SLOTS - 1);
    localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);

    tx_state_e           state, state_nx;
    logic [HW-1:0]       half_cnt;
    logic                side;
    logic [FW-1:0]       frame_cnt;
    logic [DLY_W-1:0]    dly_cnt;
    logic [PAY_BITS-1:0] word_a, word_b, word_sel;
    logic                fetching, starve;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = hold_first_b ? ST_HOLD : ST_FETCH_A;
            ST_HOLD:    if (dly_cnt == '0) state_nx = ST_FETCH_A;
            ST_FETCH_A: state_nx = mono ? ST_FETCH_B : ST_SEND;
            ST_FETCH_B: state_nx = ST_SEND;
            ST_SEND:    if (cell_en && half_cnt == LAST_HALF)
                            state_nx = (mono && !side) ? ST_SEND : ST_FETCH_A;
            default:    state_nx = ST_IDLE;
        endcase
        if (!go) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs of the state machine
    always_comb begin
        fetching   = (state == ST_FETCH_A) || (state == ST_FETCH_B);
        fifo_ready = fetching;
        starve     = fetching && !fifo_valid;
        fire       = (state == ST_SEND) && cell_en;
        line_clear = !go || (state == ST_IDLE);
        half_idx   = half_cnt;
        pre_kind   = side ? PRE_W : ((frame_cnt == '0) ? PRE_B : PRE_M);
        word_sel   = (mono && !dup_primary) ? word_b : word_a;
        payload    = {gen_parity ? ^word_sel[PAY_BITS-2:0] : word_sel[PAY_BITS-1],
                      word_sel[PAY_BITS-2:0]};
    end

    // position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt  <= '0;
            side      <= 1'b0;
            frame_cnt <= '0;
            dly_cnt   <= '0;
        end else if (state == ST_IDLE) begin
            half_cnt  <= '0;
            side      <= 1'b0;
            frame_cnt <= '0;
            dly_cnt   <= first_b_delay;
        end else begin
            if (state == ST_HOLD && cell_en && dly_cnt != '0)
                dly_cnt <= dly_cnt - 1'b1;
            if (fire) begin
                half_cnt <= half_cnt + 1'b1;
                if (half_cnt == LAST_HALF) begin
                    side <= ~side;
                    if (side)
                        frame_cnt <= (frame_cnt == LAST_FRAME) ? '0 : frame_cnt + 1'b1;
                end
            end
        end
    end

    // word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_a <= '0;
            word_b <= '0;
        end else begin
            if (state == ST_FETCH_A) word_a <= fifo_valid ? fifo_word : '0;
            if (state == ST_FETCH_B) word_b <= fifo_valid ? fifo_word : '0;
        end
    end

    // sticky underrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            underrun <= 1'b0;
        else if (starve)       underrun <= 1'b1;
        else if (underrun_clr) underrun <= 1'b0;
    end

    a_r9_underrun_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(fifo_ready && !fifo_valid));

    a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_clr && !(fifo_ready && !fifo_valid)) |=> !underrun);

    a_r10_no_fetch_off: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !fifo_ready);

    a_r6_one_fetch_per_gap: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !fifo_ready);

endmodule

// File: rtl/spdif_tx_bmc.sv
module spdif_tx_bmc
    import spdif_tx_pkg::*;
#(
    parameter int HW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                fire,
    input  logic [HW-1:0]       half_idx,
    input  pre_e                pre_kind,
    input  logic [PAY_BITS-1:0] payload,
    output logic                sdo
);

    localparam int SW = HW - 1;

    logic [SW-1:0] slot;
    logic          in_pre, cur_bit, pinv, inv;
    logic [SW-1:0] dix;
    logic [7:0]    pat;

    always_comb begin
        slot    = half_idx[HW-1:1];
        in_pre  = slot < SW'(PRE_SLOTS);
        dix     = slot - SW'(PRE_SLOTS);
        cur_bit = in_pre ? 1'b0 : payload[dix];
        pat     = pre_pattern(pre_kind);
        inv     = (half_idx == '0) ? sdo : pinv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo  <= 1'b0;
            pinv <= 1'b0;
        end else if (clear) begin
            sdo  <= 1'b0;
            pinv <= 1'b0;
        end else if (fire) begin
            if (in_pre) begin
                if (half_idx == '0) pinv <= sdo;
                sdo <= pat[3'd7 - half_idx[2:0]] ^ inv;
            end else if (!half_idx[0]) begin
                sdo <= ~sdo;
            end else if (cur_bit) begin
                sdo <= ~sdo;
            end
        end
    end

    a_r3_cell_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clear && !in_pre && !half_idx[0]) |=> (sdo != $past(sdo)));

    a_r3_zero_flat: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clear && !in_pre && half_idx[0] && !cur_bit) |=> $stable(sdo));

    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !sdo);

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
    import spdif_tx_pkg::*;
#(
    parameter int FRAMES = 192,
    parameter int DLY_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cell_en,
    input  logic                cfg_enable,
    input  logic                cfg_tx_mode,
    input  logic                cfg_mono,
    input  logic                cfg_dup_primary,
    input  logic                cfg_gen_parity,
    input  logic                cfg_hold_first_b,
    input  logic [DLY_W-1:0]    cfg_first_b_delay,
    input  logic [PAY_BITS-1:0] fifo_word,
    input  logic                fifo_valid,
    output logic                fifo_ready,
    input  logic                underrun_clr,
    output logic                underrun,
    output logic                sdo
);

    localparam int HW = $clog2(2 * SLOTS);

    logic                go, fire, line_clear;
    logic [HW-1:0]       half_idx;
    pre_e                pre_kind;
    logic [PAY_BITS-1:0] payload;

    assign go = cfg_enable && cfg_tx_mode;

    spdif_tx_ctrl #(.FRAMES(FRAMES), .DLY_W(DLY_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cell_en       (cell_en),
        .go            (go),
        .mono          (cfg_mono),
        .dup_primary   (cfg_dup_primary),
        .gen_parity    (cfg_gen_parity),
        .hold_first_b  (cfg_hold_first_b),
        .first_b_delay (cfg_first_b_delay),
        .fifo_word     (fifo_word),
        .fifo_valid    (fifo_valid),
        .fifo_ready    (fifo_ready),
        .underrun_clr  (underrun_clr),
        .underrun      (underrun),
        .fire          (fire),
        .line_clear    (line_clear),
        .half_idx      (half_idx),
        .pre_kind      (pre_kind),
        .payload       (payload)
    );

    spdif_tx_bmc #(.HW(HW)) u_bmc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (line_clear),
        .fire     (fire),
        .half_idx (half_idx),
        .pre_kind (pre_kind),
        .payload  (payload),
        .sdo      (sdo)
    );

endmodule

// File: tb/spdif_tx_tb.sv
module spdif_tx_tb;

    localparam logic [7:0] PB = 8'b1110_1000;
    localparam logic [7:0] PM = 8'b1110_0010;
    localparam logic [7:0] PW = 8'b1110_0100;
    localparam int HMAX = 25000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cell_en = 1'b0;
    logic        cfg_enable = 1'b0, cfg_tx_mode = 1'b1, cfg_mono = 1'b0;
    logic        cfg_dup_primary = 1'b0, cfg_gen_parity = 1'b1, cfg_hold_first_b = 1'b0;
    logic [7:0]  cfg_first_b_delay = 8'd0;
    logic [27:0] fifo_word;
    logic        fifo_valid, fifo_ready, underrun_clr = 1'b0, underrun, sdo;

    always #5 clk = ~clk;

    logic [27:0] fq [0:63];
    int head = 0, tail = 0;
    assign fifo_valid = (head != tail);
    assign fifo_word  = fq[head % 64];
    always @(posedge clk) if (fifo_ready && fifo_valid) head <= head + 1;

    logic hbuf [0:HMAX-1];
    int   hidx = 0, ph = 0, ready_seen = 0;
    bit   rec_on = 0;
    int   n_checks = 0, n_fail = 0;

    spdif_tx u_dut (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .cfg_enable(cfg_enable),
        .cfg_tx_mode(cfg_tx_mode), .cfg_mono(cfg_mono), .cfg_dup_primary(cfg_dup_primary),
        .cfg_gen_parity(cfg_gen_parity), .cfg_hold_first_b(cfg_hold_first_b),
        .cfg_first_b_delay(cfg_first_b_delay), .fifo_word(fifo_word), .fifo_valid(fifo_valid),
        .fifo_ready(fifo_ready), .underrun_clr(underrun_clr), .underrun(underrun), .sdo(sdo)
    );

    // half-cell strobe every third clock, and line recorder
    always @(negedge clk) begin
        if (rec_on && cell_en && hidx < HMAX) begin
            hbuf[hidx] = sdo;
            hidx++;
        end
        if (fifo_ready) ready_seen++;
        ph = (ph == 2) ? 0 : ph + 1;
        cell_en = (ph == 0);
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] exp_pay(input logic [27:0] w, input bit gen);
        return gen ? {^w[26:0], w[26:0]} : w;
    endfunction

    task automatic push(input logic [27:0] w);
        fq[tail % 64] = w;
        tail++;
    endtask

    task automatic flush();
        tail = head;
    endtask

    task automatic pulse_clear();
        @(negedge clk); #1 underrun_clr = 1'b1;
        @(negedge clk); #1 underrun_clr = 1'b0;
    endtask

    task automatic start(input bit tx, input bit mono, input bit dup, input bit gen,
                         input bit hold, input int dly);
        cfg_tx_mode = tx; cfg_mono = mono; cfg_dup_primary = dup;
        cfg_gen_parity = gen; cfg_hold_first_b = hold; cfg_first_b_delay = 8'(dly);
        @(negedge clk); #1;
        while (!cell_en) begin @(negedge clk); #1; end
        hidx = 0; rec_on = 1;
        cfg_enable = 1'b1;
    endtask

    task automatic run_halves(input int n);
        while (hidx < n) @(negedge clk);
        #1;
    endtask

    task automatic stop();
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);
        #1 rec_on = 0;
    endtask

    function automatic int first_one();
        for (int i = 0; i < hidx; i++) if (hbuf[i]) return i;
        return -1;
    endfunction

    task automatic dec(input int base, output logic [7:0] pre, output logic [27:0] pay,
                       output int err);
        logic prev;
        prev = hbuf[base - 1];
        err = 0;
        for (int k = 0; k < 8; k++) pre[7 - k] = hbuf[base + k] ^ prev;
        for (int s = 0; s < 28; s++) begin
            int i;
            i = base + 8 + 2 * s;
            if (hbuf[i] == hbuf[i - 1]) err++;
            pay[s] = (hbuf[i] != hbuf[i + 1]);
        end
    endtask

    task automatic t_reset();
        check(sdo == 1'b0, "R12 sdo", sdo, 0);
        check(underrun == 1'b0, "R12 underrun", underrun, 0);
        check(fifo_ready == 1'b0, "R12 fifo_ready", fifo_ready, 0);
    endtask

    task automatic t_stereo();
        logic [27:0] w [0:3];
        logic [7:0] exp_pre [0:3];
        logic [7:0] pre; logic [27:0] pay; int err, s0;
        w[0] = 28'h8A5C3F1; w[1] = 28'h2F0E9B7; w[2] = 28'h4C1D2E3; w[3] = 28'h7B3A596;
        exp_pre[0] = PB; exp_pre[1] = PW; exp_pre[2] = PM; exp_pre[3] = PW;
        flush();
        for (int k = 0; k < 4; k++) push(w[k]);
        start(1, 0, 0, 1, 0, 0);
        run_halves(1 + 4 * 64 + 2);
        stop();
        s0 = first_one();
        check(s0 == 1, "R1 first preamble position", s0, 1);
        for (int k = 0; k < 4; k++) begin
            dec(s0 + 64 * k, pre, pay, err);
            check(pre == exp_pre[k], "R1 preamble", pre, exp_pre[k]);
            check(pay == exp_pay(w[k], 1), "R2 R4 payload", pay, exp_pay(w[k], 1));
            check(^pay == 1'b0, "R4 even parity", ^pay, 0);
            check(err == 0, "R3 cell transitions", err, 0);
        end
        pulse_clear();
    endtask

    task automatic t_parity_pass();
        logic [27:0] w [0:1];
        logic [7:0] pre; logic [27:0] pay; int err, s0;
        w[0] = 28'h0123456; w[1] = 28'h5FEDCBA;
        for (int k = 0; k < 2; k++) w[k][27] = ~^w[k][26:0];
        flush();
        push(w[0]); push(w[1]);
        start(1, 0, 0, 0, 0, 0);
        run_halves(1 + 2 * 64 + 2);
        stop();
        s0 = first_one();
        for (int k = 0; k < 2; k++) begin
            dec(s0 + 64 * k, pre, pay, err);
            check(pay == w[k], "R5 parity passed through", pay, w[k]);
            check(err == 0, "R3 cell transitions", err, 0);
        end
        pulse_clear();
    endtask

    task automatic t_mono(input bit dup);
        logic [27:0] w [0:3];
        logic [27:0] e;
        logic [7:0] exp_pre [0:3];
        logic [7:0] pre; logic [27:0] pay; int err, s0;
        w[0] = 28'h1111A11; w[1] = 28'h2222B22; w[2] = 28'h3333C33; w[3] = 28'h4444D44;
        exp_pre[0] = PB; exp_pre[1] = PW; exp_pre[2] = PM; exp_pre[3] = PW;
        flush();
        for (int k = 0; k < 4; k++) push(w[k]);
        start(1, 1, dup, 1, 0, 0);
        run_halves(1 + 4 * 64 + 2);
        stop();
        s0 = first_one();
        for (int k = 0; k < 4; k++) begin
            e = w[2 * (k / 2) + (dup ? 0 : 1)];
            dec(s0 + 64 * k, pre, pay, err);
            check(pay == exp_pay(e, 1), "R6 single-channel word", pay, exp_pay(e, 1));
            check(pre == exp_pre[k], "R1 R6 preamble", pre, exp_pre[k]);
        end
        pulse_clear();
    endtask

    task automatic t_hold();
        int a, b;
        logic [7:0] pre; logic [27:0] pay; int err;
        flush();
        start(1, 0, 0, 1, 0, 0);
        run_halves(40);
        stop();
        a = first_one();
        start(1, 0, 0, 1, 1, 5);
        run_halves(40);
        stop();
        b = first_one();
        check(b - a == 5, "R7 hold-off delay", b - a, 5);
        run_halves(0);
        start(1, 0, 0, 1, 1, 5);
        run_halves(b + 70);
        stop();
        dec(b, pre, pay, err);
        check(pre == PB, "R7 first preamble is B", pre, PB);
        pulse_clear();
    endtask

    task automatic t_block();
        logic [7:0] pre; logic [27:0] pay; int err, s0;
        flush();
        start(1, 0, 0, 1, 0, 0);
        run_halves(1 + 386 * 64 + 2);
        check(underrun == 1'b1, "R9 underrun set", underrun, 1);
        stop();
        s0 = first_one();
        dec(s0, pre, pay, err);
        check(pay == 28'h0, "R9 zero word sent", pay, 0);
        check(pre == PB, "R8 block start B", pre, PB);
        dec(s0 + 382 * 64, pre, pay, err);
        check(pre == PM, "R8 frame 191 left M", pre, PM);
        dec(s0 + 384 * 64, pre, pay, err);
        check(pre == PB, "R8 frame 192 left B", pre, PB);
        check(err == 0, "R3 cell transitions", err, 0);
        dec(s0 + 385 * 64, pre, pay, err);
        check(pre == PW, "R8 frame 192 right W", pre, PW);
        check(underrun == 1'b1, "R9 sticky while idle", underrun, 1);
        pulse_clear();
        @(negedge clk);
        check(underrun == 1'b0, "R9 clear pulse", underrun, 0);
    endtask

    task automatic t_rx();
        int h0, ones;
        flush();
        push(28'h1234567); push(28'h7654321);
        h0 = head;
        ready_seen = 0;
        start(0, 0, 0, 1, 0, 0);
        run_halves(100);
        ones = 0;
        for (int i = 0; i < 100; i++) if (hbuf[i]) ones++;
        check(ones == 0, "R10 receive: line low", ones, 0);
        check(ready_seen == 0, "R10 receive: no ready", ready_seen, 0);
        check(head == h0, "R10 receive: no word used", head, h0);
        stop();
        cfg_tx_mode = 1'b1;
        ready_seen = 0;
        repeat (300) @(negedge clk);
        #1;
        check(ready_seen == 0 && head == h0, "R10 disabled: no fetch", ready_seen, 0);
        check(sdo == 1'b0, "R10 disabled: line low", sdo, 0);
    endtask

    task automatic t_disable();
        logic [7:0] pre; logic [27:0] pay; int err, s0;
        flush();
        for (int k = 0; k < 8; k++) push(28'h0F0F0F0 + 28'(k));
        start(1, 0, 0, 1, 0, 0);
        run_halves(1 + 3 * 64 + 20);
        stop();
        check(sdo == 1'b0, "R11 line low after disable", sdo, 0);
        check(fifo_ready == 1'b0, "R11 no ready after disable", fifo_ready, 0);
        s0 = first_one();
        dec(s0 + 128, pre, pay, err);
        check(pre == PM, "R11 frame 1 was M", pre, PM);
        flush();
        push(28'h3A3A3A3); push(28'h5C5C5C5);
        start(1, 0, 0, 1, 0, 0);
        run_halves(1 + 64 + 2);
        stop();
        s0 = first_one();
        check(s0 == 1, "R11 restart position", s0, 1);
        dec(s0, pre, pay, err);
        check(pre == PB, "R11 restart with B", pre, PB);
        check(pay == exp_pay(28'h3A3A3A3, 1), "R11 restart word", pay, exp_pay(28'h3A3A3A3, 1));
        pulse_clear();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_stereo();
        t_parity_pass();
        t_mono(1'b1);
        t_mono(1'b0);
        t_hold();
        t_rx();
        t_disable();
        t_block();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule